// File: doc/BRIEF.md
# Threshold Interrupt Controller for a Character FIFO Pair

This block sits between the host bus of one asynchronous serial channel and its line-side shifters. It stores characters in two 32-deep, 8-bit queues. The host fills one queue and the line side drains it. The line side fills the other queue and the host drains it. From a small control register it derives two threshold levels and raises two interrupt lines.

The receive line goes high once the receive queue holds enough characters. The transmit line goes high once the transmit queue has drained below its level. The transmit threshold choice is locked unless an enhanced-feature enable is set. The transmit interrupt also remembers how far the last refill went. If the refill never went past the threshold, the line waits until the queue is fully empty.

Serial shifting, baud generation, error flags, timeouts and interrupt prioritisation are handled by neighbouring blocks.

Top module: `fifo_trig_irq`

## Requirements
- R1: Each queue holds up to 32 characters of 8 bits and returns them in the order written. A popped character appears on the data output in the cycle after the pop. The count outputs give the occupancy, 0 to 32.
- R2: The receive selection `cfg_rx_sel` is loaded on every `cfg_we`. The levels are 00→8, 01→16, 10→24 and 11→28. `rx_irq` is high exactly while `rx_count` is at or above the selected level, so it drops as soon as host pops take the count below it.
- R3: The transmit selection `cfg_tx_sel` maps to levels 00→16, 01→8, 10→24 and 11→30.
- R4: A `cfg_we` loads `cfg_tx_sel` only while the enhanced-feature enable is 1. The enable is written by `feat_we` with value `feat_en`. While the enable is 0, the previous transmit selection is kept.
- R5: While the refill flag is set, `tx_irq` is high exactly when `tx_count` is below the transmit level.
- R6: The refill flag is set in the cycle after `tx_count` exceeds the transmit level. It is cleared by a host transmit push while the count is not above the level. While the flag is clear, `tx_irq` is high only when `tx_count` is 0.
- R7: A push into a full queue with no pop in the same cycle is dropped. The count stays at 32, and the queue's overflow output pulses high for one cycle after that edge.
- R8: A pop from an empty queue leaves the count at 0 and holds the data output at the last character popped.
- R9: A push and a pop in the same cycle on a non-empty queue are both performed. The count stays the same, including when the queue is full, and no overflow is flagged.
- R10: While `rst_n` is low at a clock edge, both queues are emptied, both selections and the enable are cleared, and both interrupts are low. After release, the interrupts follow R2, R5 and R6, so `tx_irq` is high from the first cycle with an empty transmit queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_rx_sel | input | 2 | Receive threshold selection written by cfg_we |
| cfg_tx_sel | input | 2 | Transmit threshold selection written by cfg_we when enabled |
| feat_we | input | 1 | Enhanced-feature enable write strobe |
| feat_en | input | 1 | Enhanced-feature enable value |
| host_tx_push | input | 1 | Host writes a character into the transmit queue |
| host_tx_data | input | 8 | Character written by the host |
| host_rx_pop | input | 1 | Host takes a character from the receive queue |
| host_rx_data | output | 8 | Character taken by the host, valid the cycle after the pop |
| line_tx_pop | input | 1 | Line side takes a character from the transmit queue |
| line_tx_data | output | 8 | Character taken by the line side, valid the cycle after the pop |
| line_rx_push | input | 1 | Line side writes a received character |
| line_rx_data | input | 8 | Received character |
| tx_count | output | 6 | Transmit queue occupancy |
| rx_count | output | 6 | Receive queue occupancy |
| tx_overflow | output | 1 | One-cycle pulse after a dropped transmit push |
| rx_overflow | output | 1 | One-cycle pulse after a dropped receive push |
| tx_irq | output | 1 | Transmit threshold interrupt |
| rx_irq | output | 1 | Receive threshold interrupt |

## Verification
The hardest condition to reach is a transmit threshold write that was silently refused while the enable was clear. It shows up only in the transmit interrupt, many cycles later. The stimulus therefore writes a new transmit selection with the enable clear and fills the queue one past the default level. It then drains the queue one character at a time and checks that the interrupt turns on at 15 characters and not at 7. The fill-history rule is reached in a similar way: a shallow refill that never passes the level is drained, and the interrupt must stay low until the queue is empty. A full-depth fill with a concurrent push and pop covers the full-queue corner, while the scoreboard checks character order on every drain.

// File: rtl/fifo_trig_pkg.sv
// Package: shared widths and threshold decode for the FIFO threshold controller.
// Assumes a fixed queue depth of 32; the level tables are defined for that depth.
package fifo_trig_pkg;
    localparam int DATA_W     = 8;
    localparam int FIFO_DEPTH = 32;
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);

    typedef logic [1:0]       trig_sel_t;
    typedef logic [CNT_W-1:0] level_t;

    // Receive threshold: uniform-ish steps toward the top of the queue.
    function automatic level_t rx_level(input trig_sel_t sel);
        case (sel)
            2'b00:   rx_level = level_t'(8);
            2'b01:   rx_level = level_t'(16);
            2'b10:   rx_level = level_t'(24);
            default: rx_level = level_t'(28);
        endcase
    endfunction

    // Transmit threshold: the reset code is the middle of the queue, not the lowest.
    function automatic level_t tx_level(input trig_sel_t sel);
        case (sel)
            2'b00:   tx_level = level_t'(16);
            2'b01:   tx_level = level_t'(8);
            2'b10:   tx_level = level_t'(24);
            default: tx_level = level_t'(30);
        endcase
    endfunction
endpackage

// File: rtl/trig_fifo.sv
// Module: trig_fifo
// Synchronous single-clock queue with registered read data and an occupancy count.
// Assumes DEPTH is a power of two so the pointers wrap naturally.
// A pop on empty is ignored and holds the read data; a push on full without a pop
// is dropped and raises a one-cycle overflow pulse.
module trig_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [WIDTH-1:0]             push_data,
    input  logic                         pop,
    output logic [WIDTH-1:0]             pop_data,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         overflow
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             full, empty, do_push, do_pop;

    // Accept decisions: a pop frees a slot for a same-cycle push.
    always_comb begin
        full    = (count == FULL_CNT);
        empty   = (count == '0);
        do_pop  = pop && !empty;
        do_push = push && (!full || do_pop);
    end

    // Storage write; no reset needed for the data array.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointers, occupancy, read data and overflow pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            pop_data <= '0;
            overflow <= 1'b0;
        end else begin
            overflow <= push && !do_push;
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop) begin
                rd_ptr   <= rd_ptr + 1'b1;
                pop_data <= mem[rd_ptr];
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);
    assert_drop_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && full) |=> (overflow && $stable(count)));
    assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && empty) |=> ($stable(pop_data) && count == '0));
    assert_push_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !empty) |=> ($stable(count) && !overflow));
endmodule

// File: rtl/trig_ctrl_regs.sv
// Module: trig_ctrl_regs
// Holds the two threshold selections and the enhanced-feature enable, and decodes
// the selections into levels. The transmit selection is write-protected while the
// enable is clear. Assumes configuration writes are single-cycle strobes.
module trig_ctrl_regs
    import fifo_trig_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cfg_we,
    input  trig_sel_t cfg_rx_sel,
    input  trig_sel_t cfg_tx_sel,
    input  logic      feat_we,
    input  logic      feat_en,
    output level_t    rx_lvl,
    output level_t    tx_lvl
);
    trig_sel_t rx_sel_q, tx_sel_q;
    logic      enh_q;

    // Enhanced-feature enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)       enh_q <= 1'b0;
        else if (feat_we) enh_q <= feat_en;
    end

    // Threshold selections; transmit field honours the enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sel_q <= '0;
            tx_sel_q <= '0;
        end else if (cfg_we) begin
            rx_sel_q <= cfg_rx_sel;
            if (enh_q) tx_sel_q <= cfg_tx_sel;
        end
    end

    // Level decode from the fixed tables.
    always_comb begin
        rx_lvl = rx_level(rx_sel_q);
        tx_lvl = tx_level(tx_sel_q);
    end

    assert_tx_sel_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !enh_q |=> $stable(tx_sel_q));
    assert_rx_sel_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (rx_sel_q == $past(cfg_rx_sel)));
endmodule

// File: rtl/tx_thresh_tracker.sv
// Module: tx_thresh_tracker
// Produces the transmit threshold interrupt with its refill history. A flag notes
// that the queue rose above the level; with the flag set the interrupt fires below
// the level, otherwise only on empty. A host push with the count not above the
// level clears the flag (interrupt taken). Assumes the count moves by at most one.
module tx_thresh_tracker
    import fifo_trig_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   en,
    input  logic   host_push,
    input  level_t count,
    input  level_t level,
    output logic   irq
);
    logic armed_q;

    // Refill-history flag: set above the level, cleared when the host reloads.
    always_ff @(posedge clk) begin
        if (!rst_n)              armed_q <= 1'b0;
        else if (count > level)  armed_q <= 1'b1;
        else if (host_push)      armed_q <= 1'b0;
    end

    // Interrupt condition chosen by the history flag.
    always_comb begin
        irq = en && (armed_q ? (count < level) : (count == '0));
    end

    assert_empty_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && count == '0) |-> irq);
    assert_arm_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (count > level) |=> armed_q);
endmodule

// File: rtl/fifo_trig_irq.sv
// Module: fifo_trig_irq (top)
// Transmit and receive character queues of one serial channel with threshold
// interrupts. Host pushes transmit / pops receive; line side pops transmit /
// pushes receive. Assumes a single clock and a synchronous active-low reset.
module fifo_trig_irq
    import fifo_trig_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_rx_sel,
    input  logic [1:0]        cfg_tx_sel,
    input  logic              feat_we,
    input  logic              feat_en,
    input  logic              host_tx_push,
    input  logic [DATA_W-1:0] host_tx_data,
    input  logic              host_rx_pop,
    output logic [DATA_W-1:0] host_rx_data,
    input  logic              line_tx_pop,
    output logic [DATA_W-1:0] line_tx_data,
    input  logic              line_rx_push,
    input  logic [DATA_W-1:0] line_rx_data,
    output logic [CNT_W-1:0]  tx_count,
    output logic [CNT_W-1:0]  rx_count,
    output logic              tx_overflow,
    output logic              rx_overflow,
    output logic              tx_irq,
    output logic              rx_irq
);
    level_t rx_lvl, tx_lvl;
    logic   live_q;

    // Interrupts stay quiet through reset; live from the first cycle after.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    trig_ctrl_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_rx_sel (cfg_rx_sel),
        .cfg_tx_sel (cfg_tx_sel),
        .feat_we    (feat_we),
        .feat_en    (feat_en),
        .rx_lvl     (rx_lvl),
        .tx_lvl     (tx_lvl)
    );

    trig_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (host_tx_push),
        .push_data (host_tx_data),
        .pop       (line_tx_pop),
        .pop_data  (line_tx_data),
        .count     (tx_count),
        .overflow  (tx_overflow)
    );

    trig_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (line_rx_push),
        .push_data (line_rx_data),
        .pop       (host_rx_pop),
        .pop_data  (host_rx_data),
        .count     (rx_count),
        .overflow  (rx_overflow)
    );

    tx_thresh_tracker u_tx_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (live_q),
        .host_push (host_tx_push),
        .count     (tx_count),
        .level     (tx_lvl),
        .irq       (tx_irq)
    );

    // Receive interrupt: level-sensitive on occupancy.
    always_comb begin
        rx_irq = live_q && (rx_count >= rx_lvl);
    end

    assert_rx_irq_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq) |-> ($past(line_rx_push) || $past(cfg_we)));
    assert_tx_irq_below_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> (tx_count < tx_lvl || tx_count == '0));
endmodule

// File: tb/tb_fifo_trig_irq.sv
module tb_fifo_trig_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0, feat_we = 1'b0, feat_en = 1'b0;
    logic [1:0] cfg_rx_sel = '0, cfg_tx_sel = '0;
    logic       host_tx_push = 1'b0, host_rx_pop = 1'b0;
    logic       line_tx_pop = 1'b0, line_rx_push = 1'b0;
    logic [7:0] host_tx_data = '0, line_rx_data = '0;
    logic [7:0] host_rx_data, line_tx_data;
    logic [5:0] tx_count, rx_count;
    logic       tx_overflow, rx_overflow, tx_irq, rx_irq;

    int n_chk = 0, n_err = 0;
    logic [7:0] txq[$], rxq[$];
    logic [7:0] tx_exp, rx_exp, rx_last;
    bit tx_pend = 0, rx_pend = 0, done = 0;
    logic [7:0] seed = 8'h11;

    always #2 clk = ~clk;

    fifo_trig_irq dut (.*);

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(); @(negedge clk); endtask

    // Driver tasks: the expected queue is updated as the stimulus is applied.
    task automatic tx_push(logic [7:0] d);
        host_tx_push = 1'b1; host_tx_data = d;
        if (txq.size() < 32 || line_tx_pop) txq.push_back(d);
        tick(); host_tx_push = 1'b0;
    endtask
    task automatic rx_push(logic [7:0] d);
        line_rx_push = 1'b1; line_rx_data = d;
        if (rxq.size() < 32 || host_rx_pop) rxq.push_back(d);
        tick(); line_rx_push = 1'b0;
    endtask
    task automatic tx_pop(); line_tx_pop = 1'b1; tick(); line_tx_pop = 1'b0; endtask
    task automatic rx_pop(); host_rx_pop = 1'b1; tick(); host_rx_pop = 1'b0; endtask
    task automatic tx_fill(int n);
        for (int i = 0; i < n; i++) begin seed = seed * 8'd5 + 8'd3; tx_push(seed); end
    endtask
    task automatic rx_fill(int n);
        for (int i = 0; i < n; i++) begin seed = seed * 8'd7 + 8'd1; rx_push(seed); end
    endtask
    task automatic cfg(logic [1:0] rs, logic [1:0] ts);
        cfg_we = 1'b1; cfg_rx_sel = rs; cfg_tx_sel = ts; tick(); cfg_we = 1'b0;
    endtask
    task automatic feat(logic v);
        feat_we = 1'b1; feat_en = v; tick(); feat_we = 1'b0;
    endtask
    task automatic tx_drain_to(int n);
        while (tx_count > n) tx_pop();
    endtask

    // Monitor: takes the expected character as a pop is accepted, compares after the edge.
    always @(posedge clk) begin
        if (rst_n) begin
            if (line_tx_pop && txq.size() > 0) begin tx_exp = txq.pop_front(); tx_pend = 1; end
            if (host_rx_pop && rxq.size() > 0) begin rx_exp = rxq.pop_front(); rx_pend = 1; end
        end
    end
    always @(negedge clk) begin
        if (tx_pend) begin chk("R1 tx order", line_tx_data, tx_exp); tx_pend = 0; end
        if (rx_pend) begin chk("R1 rx order", host_rx_data, rx_exp); rx_last = rx_exp; rx_pend = 0; end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        tick(); tick();
        chk("R10 tx_irq in reset", tx_irq, 0);
        chk("R10 rx_irq in reset", rx_irq, 0);
        chk("R10 counts in reset", tx_count + rx_count, 0);
        rst_n = 1'b1; tick();
        chk("R10 tx_irq empty after release", tx_irq, 1);
        chk("R10 rx_irq after release", rx_irq, 0);

        // R2: default receive level 8, then each selection
        rx_fill(7);  chk("R2 rx_irq at 7 lvl8", rx_irq, 0);
        rx_fill(1);  chk("R2 rx_irq at 8 lvl8", rx_irq, 1);
        chk("R1 rx_count", rx_count, 8);
        rx_pop();    chk("R2 rx_irq drops at 7", rx_irq, 0);
        cfg(2'b01, 2'b11);
        rx_fill(8);  chk("R2 rx_irq at 15 lvl16", rx_irq, 0);
        rx_fill(1);  chk("R2 rx_irq at 16 lvl16", rx_irq, 1);
        cfg(2'b10, 2'b00); chk("R2 rx_irq at 16 lvl24", rx_irq, 0);
        rx_fill(7);  chk("R2 rx_irq at 23 lvl24", rx_irq, 0);
        rx_fill(1);  chk("R2 rx_irq at 24 lvl24", rx_irq, 1);
        cfg(2'b11, 2'b00); chk("R2 rx_irq at 24 lvl28", rx_irq, 0);
        rx_fill(3);  chk("R2 rx_irq at 27 lvl28", rx_irq, 0);
        rx_fill(1);  chk("R2 rx_irq at 28 lvl28", rx_irq, 1);
        rx_fill(4);  chk("R1 rx full count", rx_count, 32);
        // R7: drop on full
        rx_fill(1);
        chk("R7 rx overflow pulse", rx_overflow, 1);
        chk("R7 rx count held", rx_count, 32);
        tick();      chk("R7 rx overflow one cycle", rx_overflow, 0);
        // R9: push and pop together on full
        host_rx_pop = 1'b1; rx_fill(1); host_rx_pop = 1'b0;
        chk("R9 rx count full push+pop", rx_count, 32);
        chk("R9 rx no overflow", rx_overflow, 0);
        while (rx_count > 0) rx_pop();
        chk("R2 rx_irq empty", rx_irq, 0);
        // R8: pop on empty
        rx_pop();
        chk("R8 rx data held", host_rx_data, rx_last);
        chk("R8 rx count stays 0", rx_count, 0);

        // R4 + R5: transmit selection refused while enable clear (selection 01 ignored)
        cfg(2'b00, 2'b01);
        tx_fill(17); chk("R6 tx_irq quiet when filled", tx_irq, 0);
        tx_pop();    chk("R4 tx_irq at 16 level still 16", tx_irq, 0);
        tx_pop();    chk("R4 R5 tx_irq at 15 level 16", tx_irq, 1);
        tx_drain_to(0); chk("R5 tx_irq empty", tx_irq, 1);
        tx_pop();    chk("R8 tx count stays 0", tx_count, 0);
        // R6: shallow refill never above level
        tx_fill(10); chk("R6 tx_irq cleared by reload", tx_irq, 0);
        tx_drain_to(1); chk("R6 tx_irq quiet at 1", tx_irq, 0);
        tx_pop();    chk("R6 tx_irq at empty", tx_irq, 1);

        // R3: enabled selections
        feat(1'b1); cfg(2'b00, 2'b01);
        tx_fill(9);  tx_pop(); chk("R3 tx_irq at 8 lvl8", tx_irq, 0);
        tx_pop();    chk("R3 tx_irq at 7 lvl8", tx_irq, 1);
        tx_drain_to(0);
        cfg(2'b00, 2'b10);
        tx_fill(25); tx_pop(); chk("R3 tx_irq at 24 lvl24", tx_irq, 0);
        tx_pop();    chk("R3 tx_irq at 23 lvl24", tx_irq, 1);
        tx_drain_to(0);
        cfg(2'b00, 2'b11);
        tx_fill(31); tx_pop(); chk("R3 tx_irq at 30 lvl30", tx_irq, 0);
        tx_pop();    chk("R3 tx_irq at 29 lvl30", tx_irq, 1);
        tx_fill(3);  chk("R1 tx full count", tx_count, 32);
        tx_fill(1);
        chk("R7 tx overflow pulse", tx_overflow, 1);
        chk("R7 tx count held", tx_count, 32);
        line_tx_pop = 1'b1; tx_fill(1); line_tx_pop = 1'b0;
        chk("R9 tx count full push+pop", tx_count, 32);
        chk("R9 tx no overflow", tx_overflow, 0);
        tx_drain_to(0);
        chk("R1 tx drained", tx_count, 0);

        // R10: reset restores levels and the write lock
        cfg(2'b11, 2'b11); rx_fill(5); tx_fill(3);
        rst_n = 1'b0; txq.delete(); rxq.delete(); tick();
        chk("R10 counts cleared", tx_count + rx_count, 0);
        chk("R10 irqs low", tx_irq + rx_irq, 0);
        rst_n = 1'b1; tick();
        rx_fill(7);  chk("R10 rx level back to 8 (7)", rx_irq, 0);
        rx_fill(1);  chk("R10 rx level back to 8 (8)", rx_irq, 1);
        cfg(2'b00, 2'b11);
        tx_fill(17); tx_pop(); tx_pop();
        chk("R10 enable cleared, tx level 16", tx_irq, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule